// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control that paces an analog-to-digital converter. It divides the CPU clock into a slower converter clock, then counts converter clock cycles to place two events: the sample-and-hold strobe and the end of conversion. At the end of a conversion it captures a result word, pulses a result-register write strobe and raises a sticky done flag. The analog comparator and DAC are outside the block. The result word arrives on an input.

Software starts a conversion with a start request. The block can also restart on its own (free-running) or start from a trigger edge. The trigger edge comes either from an external pin or from the block's own done flag. The first conversion after the enable rises is longer, so that the analog side has time to initialise. A trigger edge restarts the divider, which gives a fixed delay from the edge to the sample point.

Top module: `adc_conv_seq`

## Requirements
- R1: While `adc_en` is low the divider is held cleared and `adc_clk` is low. The divide ratio is 2^`presc_sel`, with 0 treated as 1, so the ratios run from 2 to 128. `adc_clk` is high in the first half of each period, and its first rising edge falls in the cycle in which `adc_en` goes high.
- R2: A start request raises `start_bit` on the next CPU clock. The conversion begins at the next converter-clock rising edge, and a normal conversion lasts 13 converter cycles. If the conversion starts in CPU cycle C0, `res_we` pulses in cycle C0+13*DIV+1.
- R3: The first conversion after `adc_en` rises lasts 25 converter cycles. This holds again after an abort.
- R4: `sh_strobe` is a one-CPU-cycle pulse at the falling converter-clock edge. It comes 1.5 converter cycles after a normal start (cycle C0+DIV+DIV/2) and 14.5 cycles after a first-conversion start (C0+14*DIV+DIV/2).
- R5: At completion, `res_we` pulses for exactly one cycle, `result` takes `result_in`, and `done_flag` rises in the same cycle.
- R6: Outside free-running mode, `start_bit` falls in the same cycle in which `done_flag` rises.
- R7: In free-running mode (`mode`=01), the next conversion starts at the completing edge, so writes come every 13*DIV cycles and `start_bit` stays high. Leaving the mode lets the running conversion finish, and then the block stops.
- R8: In pin-trigger mode (`mode`=10), a rising edge on `trig_src` passes through three CPU cycles of synchronisation and then clears the divider. With the edge seen in cycle T, `sh_strobe` pulses in cycle T+3+DIV+DIV/2 and `res_we` pulses in cycle T+4+13*DIV.
- R9: In done-trigger mode (`mode`=11), the rising edge of `done_flag` is the trigger. It starts one more conversion, whose write follows the previous one by 13*DIV+4 cycles. While the flag stays high, no further conversion starts.
- R10: `done_flag` stays set until a `done_clr` pulse clears it. When a completion and a clear fall in the same cycle, the flag ends up set.
- R11: A start request or trigger edge that arrives during a conversion has no effect: the conversion keeps its completion time and produces one write.
- R12: Dropping `adc_en` during a conversion aborts it. There is no write, `start_bit` clears, and the next conversion is a first conversion.
- R13: A start request made while `adc_en` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_en | input | 1 | Converter enable; clears the divider while low |
| start_set | input | 1 | Software start request pulse |
| done_clr | input | 1 | Write-one-to-clear for the done flag |
| trig_src | input | 1 | External trigger source |
| mode | input | 2 | 00 single, 01 free-running, 10 pin trigger, 11 done trigger |
| presc_sel | input | SEL_W | Divider select, ratio 2^sel |
| result_in | input | RES_W | Result word captured at completion |
| adc_clk | output | 1 | Divided converter clock |
| sh_strobe | output | 1 | Sample-and-hold pulse |
| start_bit | output | 1 | Start/busy bit |
| done_flag | output | 1 | Sticky conversion-done flag |
| res_we | output | 1 | Result register write strobe |
| result | output | RES_W | Captured result |

## Verification
Two functions can fall in the same cycle: setting the done flag at completion and clearing it by write-one-to-clear. The bench locates the converter edge at which the conversion starts and computes from it the exact CPU cycle of the completion edge. It then drives `done_clr` in that cycle and expects the flag to read set on the next cycle. A second clear, made on its own afterwards, must bring the flag low.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE    = 2'b00,
      MODE_FREE      = 2'b01,
      MODE_TRIG_PIN  = 2'b10,
      MODE_TRIG_DONE = 2'b11
   } mode_t;

endpackage

// File: rtl/adcseq_presc.sv
module adcseq_presc #(
   parameter int DIV_LOG_MAX = 7,
   parameter int SEL_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sync_clr,
   input  logic [SEL_W-1:0] sel,
   output logic             rise,
   output logic             fall,
   output logic             adc_clk
);

   localparam int CNT_W = DIV_LOG_MAX;

   logic [CNT_W-1:0] pcnt;
   logic [SEL_W-1:0] shift_eff;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] last_val;
   logic [CNT_W-1:0] half_val;

   // divide ratio 2^sel, select 0 behaves as 1, clamp at the maximum
   always_comb begin
      if (sel == '0)
         shift_eff = SEL_W'(1);
      else if (sel > SEL_W'(DIV_LOG_MAX))
         shift_eff = SEL_W'(DIV_LOG_MAX);
      else
         shift_eff = sel;
      span     = (CNT_W+1)'(1) << shift_eff;
      last_val = CNT_W'(span - (CNT_W+1)'(1));
      half_val = CNT_W'(span >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (!en || sync_clr)
         pcnt <= '0;
      else if (pcnt >= last_val)
         pcnt <= '0;
      else
         pcnt <= pcnt + CNT_W'(1);
   end

   assign rise    = en && (pcnt == '0);
   assign fall    = en && (pcnt == half_val);
   assign adc_clk = en && (pcnt < half_val);

   assert_first_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> adc_clk);

   assert_clk_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pcnt == '0) || en);

endmodule

// File: rtl/adcseq_trig_sync.sv
module adcseq_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   output logic evt
);

   if (STAGES == 0) begin : g_direct
      logic last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last <= 1'b0;
         else        last <= src;
      end
      assign evt = src & ~last;
   end else begin : g_chain
      logic [STAGES-1:0] ff;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ff   <= '0;
            last <= 1'b0;
         end else begin
            ff[0] <= src;
            for (int i = 1; i < STAGES; i++)
               ff[i] <= ff[i-1];
            last <= ff[STAGES-1];
         end
      end
      assign evt = ff[STAGES-1] & ~last;
   end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
   import adcseq_pkg::*;
#(
   parameter int RES_W        = 10,
   parameter int NORM_LEN     = 13,
   parameter int FIRST_LEN    = 25,
   parameter int NORM_SAMPLE  = 2,
   parameter int FIRST_SAMPLE = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rise,
   input  logic             fall,
   input  logic             start_set,
   input  logic             trig_go,
   input  logic             done_clr,
   input  mode_t            mode,
   input  logic [RES_W-1:0] result_in,
   output logic             start_q,
   output logic             conv_q,
   output logic             sh_strobe,
   output logic             done_q,
   output logic             we_q,
   output logic [RES_W-1:0] res_q
);

   localparam int CYC_W = $clog2(FIRST_LEN + 1);
   localparam logic [CYC_W-1:0] NORM_END  = CYC_W'(NORM_LEN);
   localparam logic [CYC_W-1:0] FIRST_END = CYC_W'(FIRST_LEN);
   localparam logic [CYC_W-1:0] NORM_SMP  = CYC_W'(NORM_SAMPLE);
   localparam logic [CYC_W-1:0] FIRST_SMP = CYC_W'(FIRST_SAMPLE);

   logic [CYC_W-1:0] cyc_q;
   logic             long_q;
   logic             first_q;
   logic [CYC_W-1:0] end_idx;
   logic [CYC_W-1:0] smp_idx;
   logic             complete;
   logic             begin_c;

   always_comb begin
      end_idx  = long_q ? FIRST_END : NORM_END;
      smp_idx  = long_q ? FIRST_SMP : NORM_SMP;
      complete = conv_q && rise && (cyc_q == end_idx);
      begin_c  = !conv_q && start_q && rise;
   end

   assign sh_strobe = conv_q && fall && (cyc_q == smp_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         conv_q  <= 1'b0;
         cyc_q   <= '0;
         long_q  <= 1'b0;
         first_q <= 1'b1;
         done_q  <= 1'b0;
         we_q    <= 1'b0;
         res_q   <= '0;
      end else if (!en) begin
         // abort: drop any pending or running conversion, re-arm the long one
         start_q <= 1'b0;
         conv_q  <= 1'b0;
         cyc_q   <= '0;
         long_q  <= 1'b0;
         first_q <= 1'b1;
         we_q    <= 1'b0;
         if (done_clr) done_q <= 1'b0;
      end else begin
         we_q <= complete;
         if (complete) res_q <= result_in;

         // completion has priority over the software clear
         if (complete)      done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;

         if (complete)                    start_q <= (mode == MODE_FREE);
         else if (start_set || trig_go)   start_q <= 1'b1;

         if (complete) begin
            if (mode == MODE_FREE) begin
               cyc_q  <= CYC_W'(1);
               long_q <= 1'b0;
            end else begin
               conv_q <= 1'b0;
               cyc_q  <= '0;
            end
         end else if (begin_c) begin
            conv_q  <= 1'b1;
            cyc_q   <= CYC_W'(1);
            long_q  <= first_q;
            first_q <= 1'b0;
         end else if (conv_q && rise) begin
            cyc_q <= cyc_q + CYC_W'(1);
         end
      end
   end

   assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);

   assert_we_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> done_q);

   assert_start_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we_q && $past(mode) != MODE_FREE) |-> !start_q);

   assert_free_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_q && $past(mode) == MODE_FREE) |-> (start_q && conv_q));

   assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!we_q && !conv_q));

   assert_cyc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_q |-> (cyc_q >= CYC_W'(1) && cyc_q <= FIRST_END));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adcseq_pkg::*;
#(
   parameter int RES_W        = 10,
   parameter int SEL_W        = 3,
   parameter int DIV_LOG_MAX  = 7,
   parameter int NORM_LEN     = 13,
   parameter int FIRST_LEN    = 25,
   parameter int NORM_SAMPLE  = 2,
   parameter int FIRST_SAMPLE = 15,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adc_en,
   input  logic             start_set,
   input  logic             done_clr,
   input  logic             trig_src,
   input  logic [1:0]       mode,
   input  logic [SEL_W-1:0] presc_sel,
   input  logic [RES_W-1:0] result_in,
   output logic             adc_clk,
   output logic             sh_strobe,
   output logic             start_bit,
   output logic             done_flag,
   output logic             res_we,
   output logic [RES_W-1:0] result
);

   if (DIV_LOG_MAX < 1 || (1 << SEL_W) <= DIV_LOG_MAX) begin : g_bad_div
      $error("adc_conv_seq: divider select cannot reach DIV_LOG_MAX");
   end
   if (FIRST_LEN < NORM_LEN || NORM_SAMPLE >= NORM_LEN) begin : g_bad_len
      $error("adc_conv_seq: inconsistent conversion lengths");
   end
   if (FIRST_SAMPLE >= FIRST_LEN || NORM_SAMPLE < 2) begin : g_bad_smp
      $error("adc_conv_seq: sample cycle out of range");
   end

   mode_t mode_e;
   logic  rise, fall;
   logic  conv, done_q;
   logic  trig_in, trig_evt, trig_go;

   assign mode_e  = mode_t'(mode);
   assign trig_in = (mode_e == MODE_TRIG_DONE) ? done_q : trig_src;
   assign trig_go = trig_evt && adc_en && !conv &&
                    (mode_e == MODE_TRIG_PIN || mode_e == MODE_TRIG_DONE);

   adcseq_presc #(
      .DIV_LOG_MAX (DIV_LOG_MAX),
      .SEL_W       (SEL_W)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (adc_en),
      .sync_clr (trig_go),
      .sel      (presc_sel),
      .rise     (rise),
      .fall     (fall),
      .adc_clk  (adc_clk)
   );

   adcseq_trig_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (trig_in),
      .evt   (trig_evt)
   );

   adcseq_ctrl #(
      .RES_W        (RES_W),
      .NORM_LEN     (NORM_LEN),
      .FIRST_LEN    (FIRST_LEN),
      .NORM_SAMPLE  (NORM_SAMPLE),
      .FIRST_SAMPLE (FIRST_SAMPLE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (adc_en),
      .rise      (rise),
      .fall      (fall),
      .start_set (start_set),
      .trig_go   (trig_go),
      .done_clr  (done_clr),
      .mode      (mode_e),
      .result_in (result_in),
      .start_q   (start_bit),
      .conv_q    (conv),
      .sh_strobe (sh_strobe),
      .done_q    (done_q),
      .we_q      (res_we),
      .res_q     (result)
   );

   assign done_flag = done_q;

   assert_trig_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_go |=> (adc_clk || !adc_en));

   assert_sample_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sh_strobe |-> !adc_clk);

   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (conv && trig_evt && adc_en) |=> !(adc_clk && $past(!adc_clk) && !rise));

endmodule

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;

   localparam int CLK_PERIOD = 10;
   localparam int RES_W = 10;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             adc_en, start_set, done_clr, trig_src;
   logic [1:0]       mode;
   logic [2:0]       presc_sel;
   logic [RES_W-1:0] result_in;
   logic             adc_clk, sh_strobe, start_bit, done_flag, res_we;
   logic [RES_W-1:0] result;

   adc_conv_seq u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .adc_en    (adc_en),
      .start_set (start_set),
      .done_clr  (done_clr),
      .trig_src  (trig_src),
      .mode      (mode),
      .presc_sel (presc_sel),
      .result_in (result_in),
      .adc_clk   (adc_clk),
      .sh_strobe (sh_strobe),
      .start_bit (start_bit),
      .done_flag (done_flag),
      .res_we    (res_we),
      .result    (result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc_n = 0;
   always @(posedge clk) cyc_n <= cyc_n + 1;

   int n_chk = 0, n_fail = 0;
   int dv = 2;
   int sh_cnt = 0, sh_at = -1, we_cnt = 0, we_at = -1, we_prev = -1;
   int done_rise = -1, start_fall = -1, rise_at = -1, rise_prev = -1;
   logic done_d = 0, start_d = 0, clk_d = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sh_strobe) begin sh_cnt++; sh_at = cyc_n; end
         if (res_we) begin we_cnt++; we_prev = we_at; we_at = cyc_n; end
         if (done_flag && !done_d) done_rise = cyc_n;
         if (!start_bit && start_d) start_fall = cyc_n;
         if (adc_clk && !clk_d) begin rise_prev = rise_at; rise_at = cyc_n; end
      end
      done_d  = done_flag;
      start_d = start_bit;
      clk_d   = adc_clk;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_counts();
      sh_cnt = 0; we_cnt = 0; sh_at = -1; we_at = -1; we_prev = -1;
   endtask

   task automatic set_div(input int sel);
      presc_sel = 3'(sel);
      dv = 1 << ((sel == 0) ? 1 : sel);
      step(2 * dv + 2);
   endtask

   task automatic pulse_start();
      start_set = 1'b1; step(1); start_set = 1'b0;
   endtask

   task automatic pulse_clr();
      done_clr = 1'b1; step(1); done_clr = 1'b0;
   endtask

   // start at cycle s, return the converter rising edge that begins the conversion
   task automatic start_and_find(output int c0);
      int s;
      s = cyc_n;
      pulse_start();
      while (rise_at <= s) step(1);
      c0 = rise_at;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; adc_en = 0; start_set = 0; done_clr = 0; trig_src = 0;
      mode = 2'b00; presc_sel = 3'd1; result_in = '0;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1", "adc_clk after reset", int'(adc_clk), 0);
      chk("R5", "done after reset", int'(done_flag), 0);
      chk("R6", "start after reset", int'(start_bit), 0);
      chk("R5", "result after reset", int'(result), 0);
   endtask

   task automatic t_first_conv();
      int e;
      clear_counts();
      dv = 2; result_in = 10'h2A5;
      adc_en = 1'b1; start_set = 1'b1;
      e = cyc_n;
      step(1); start_set = 1'b0;
      step(30 * dv + 6);
      chk("R3", "first conversion write cycle", we_at, e + dv + 25 * dv + 1);
      chk("R4", "first conversion sample cycle", sh_at, e + dv + 14 * dv + dv / 2);
      chk("R4", "sample pulses", sh_cnt, 1);
      chk("R5", "write pulses", we_cnt, 1);
      chk("R5", "done rises with write", done_rise, we_at);
      chk("R5", "result captured", int'(result), 'h2A5);
      chk("R6", "start falls with done", start_fall, done_rise);
   endtask

   task automatic t_divider();
      set_div(3);
      chk("R1", "period for select 3", rise_at - rise_prev, 8);
      set_div(0);
      chk("R1", "period for select 0", rise_at - rise_prev, 2);
      set_div(7);
      step(130);
      chk("R1", "period for select 7", rise_at - rise_prev, 128);
   endtask

   task automatic t_normal();
      int c0;
      set_div(2);
      clear_counts();
      result_in = 10'h133;
      start_and_find(c0);
      step(14 * dv + 4);
      chk("R2", "normal write cycle", we_at, c0 + 13 * dv + 1);
      chk("R4", "normal sample cycle", sh_at, c0 + dv + dv / 2);
      chk("R5", "result captured", int'(result), 'h133);
   endtask

   task automatic t_free();
      int c0, n0;
      set_div(1);
      pulse_clr();
      mode = 2'b01;
      clear_counts();
      start_and_find(c0);
      step(3 * 13 * dv + 4);
      chk("R7", "free-running spacing", we_at - we_prev, 13 * dv);
      chk("R7", "start stays high", int'(start_bit), 1);
      mode = 2'b00;
      n0 = we_cnt;
      step(30 * dv);
      chk("R7", "one more write after leaving", we_cnt, n0 + 1);
      chk("R7", "start low after leaving", int'(start_bit), 0);
   endtask

   task automatic t_clear_collide();
      int c0;
      set_div(1);
      pulse_clr();
      chk("R10", "clear lowers done", int'(done_flag), 0);
      start_and_find(c0);
      step(c0 + 13 * dv - cyc_n);
      pulse_clr();
      chk("R10", "set wins over clear", int'(done_flag), 1);
      pulse_clr();
      chk("R10", "clear alone", int'(done_flag), 0);
   endtask

   task automatic t_trig_pin();
      int t;
      mode = 2'b10; trig_src = 1'b0;
      set_div(2);
      clear_counts();
      result_in = 10'h0F1;
      trig_src = 1'b1;
      t = cyc_n;
      step(20); trig_src = 1'b0;
      step(4);  trig_src = 1'b1;
      step(4);  trig_src = 1'b0;
      step(t + 70 - cyc_n);
      chk("R8", "trigger to sample", sh_at, t + 3 + dv + dv / 2);
      chk("R8", "trigger to write", we_at, t + 4 + 13 * dv);
      chk("R11", "second edge ignored, writes", we_cnt, 1);
      chk("R8", "result captured", int'(result), 'h0F1);
   endtask

   task automatic t_trig_done();
      mode = 2'b00;
      pulse_clr();
      mode = 2'b11;
      set_div(1);
      clear_counts();
      pulse_start();
      step(2 * 13 * dv + 20);
      chk("R9", "chained writes", we_cnt, 2);
      chk("R9", "chain spacing", we_at - we_prev, 13 * dv + 4);
      step(60);
      chk("R9", "no chain while flag held", we_cnt, 2);
      mode = 2'b00;
   endtask

   task automatic t_busy_start();
      int c0;
      set_div(1);
      clear_counts();
      start_and_find(c0);
      step(c0 + 5 * dv - cyc_n);
      pulse_start();
      step(30 * dv);
      chk("R11", "start during conversion, writes", we_cnt, 1);
      chk("R11", "completion time kept", we_at, c0 + 13 * dv + 1);
      chk("R11", "start low afterwards", int'(start_bit), 0);
   endtask

   task automatic t_disabled_and_abort();
      int e2;
      set_div(1);
      adc_en = 1'b0; step(2);
      clear_counts();
      pulse_start();
      chk("R13", "start while disabled", int'(start_bit), 0);
      adc_en = 1'b1;
      step(30 * dv);
      chk("R13", "no conversion from ignored start", we_cnt, 0);
      adc_en = 1'b0; step(2);
      result_in = 10'h055;
      adc_en = 1'b1; pulse_start();
      step(8 * dv);
      adc_en = 1'b0; step(1);
      chk("R12", "start cleared by abort", int'(start_bit), 0);
      chk("R1", "clock low while disabled", int'(adc_clk), 0);
      result_in = 10'h3C3;
      step(30 * dv);
      chk("R12", "no write after abort", we_cnt, 0);
      chk("R12", "result untouched", int'(result), 'h0F1);
      adc_en = 1'b1; start_set = 1'b1;
      e2 = cyc_n;
      step(1); start_set = 1'b0;
      step(30 * dv);
      chk("R12", "first-length after abort", we_at, e2 + 26 * dv + 1);
      chk("R3", "result after re-enable", int'(result), 'h3C3);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_first_conv();
      t_divider();
      t_normal();
      t_free();
      t_clear_collide();
      t_trig_pin();
      t_trig_done();
      t_busy_start();
      t_disabled_and_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule